// File: doc/BRIEF.md
# Multidrop 9-Bit Serial Receiver

This block is the receive half of a serial port used on shared multidrop buses. Each character on the line has nine payload bits. The ninth bit tells an address character (1) apart from a data character (0). The block does these jobs in order:

- It oversamples the line with a 16x sample strobe.
- It frames each character as a start bit, eight data bits, the flag bit and a stop bit.
- It passes each good character to a small address-gating state machine. That machine decides whether the character goes into an eight-entry receive FIFO.

With multidrop mode on, the receiver starts out armed and throws away data characters. An address character is stored, and the machine moves to capturing. From then on every character is stored, until detection is re-armed. Three things re-arm it:

- taking the enable low;
- a soft-reset pulse;
- when the auto-rearm control is set, the line going idle after a stored character.

An idle line raises a sticky flag that marks the end of a message. Software reads characters through a show-ahead FIFO port. Each entry keeps the flag bit next to the eight data bits. Address matching, transmission and baud generation are left to neighbouring logic.

Top module: `mdrop_rx`

## Requirements
- R1: A character is a low start bit, eight data bits sent least significant bit first, the flag bit, then a high stop bit. Each bit lasts 16 `sample_tick` strobes and is sampled at mid-bit. A stored entry reads back as `rd_data[7:0]` = data and `rd_data[8]` = flag.
- R2: With `md_enable` high and detection armed, a character whose flag bit is 0 is dropped and is not written to the FIFO.
- R3: With `md_enable` high, a character whose flag bit is 1 is stored and moves detection to capturing (`addr_seen` = 1). Every later character is then stored, whatever its flag bit.
- R4: While `md_enable` is low, detection is held armed. After `md_enable` goes high again, data characters are dropped until the next address character.
- R5: With `md_enable` low, every good character is stored together with its flag bit.
- R6: After a stored character, once the line has stayed high for 11 bit times (176 strobes) with no new start bit, `idle_flag` is set. It stays set until a pulse on `idle_clr`.
- R7: With `auto_rearm` high, the idle event also returns detection to armed. With `auto_rearm` low, capturing continues after idle.
- R8: The FIFO holds 8 entries and is read in order, with the oldest entry shown on `rd_data` while `rd_valid` is 1. A character that arrives while the FIFO is full is dropped and sets the sticky `overrun` flag.
- R9: A start bit is accepted only if the line is still low half a bit time (8 strobes) after the falling edge. A shorter low pulse produces no character and no error.
- R10: A low stop bit sets the sticky `frame_err` flag and discards the character. The receiver then waits for the line to return high before it looks for a new start bit.
- R11: A `soft_reset` pulse has these effects:
  - it empties the FIFO;
  - it re-arms detection;
  - it clears `idle_flag`, `overrun` and `frame_err`;
  - it aborts any character in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | 16x oversampling strobe |
| rx_in | input | 1 | Serial receive line, idle high |
| md_enable | input | 1 | Multidrop address gating enable |
| auto_rearm | input | 1 | Re-arm detection on idle |
| soft_reset | input | 1 | Synchronous receive-path reset pulse |
| idle_clr | input | 1 | Write-one pulse that clears `idle_flag` |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 9 | Oldest entry: flag bit in bit 8, data in bits 7:0 |
| rd_valid | output | 1 | FIFO not empty |
| addr_seen | output | 1 | Detection is capturing (not armed) |
| idle_flag | output | 1 | Sticky idle-line flag |
| overrun | output | 1 | Sticky FIFO overrun flag |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The address gating is driven with four input patterns:

- Runs of data characters while armed, which show that dropping happens.
- An address followed by data characters, which shows that capture is kept for characters whose flag is 0.
- Enable toggles and soft resets in the middle of a message, which show that re-arming works, kept apart from plain disabled mode where everything is stored.
- A seeded random stream that mixes flag bits, byte values, gaps and enable changes. Each character is compared with a bench model.

The idle tests sample just before and just after the 11-bit window, both with and without auto-rearm. This tells the idle flag apart from the re-arm action. Short low glitches, low stop bits and a ninth character into a full FIFO separate start validation, framing errors and overrun drops from normal storage.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
   localparam int CHAR_W = 9;
   typedef logic [CHAR_W-1:0] rx_char_t;
   typedef enum logic [2:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP, FR_BREAK} fr_state_e;
   typedef enum logic {DET_ARMED, DET_CAPTURE} det_state_e;
endpackage

// File: rtl/mdrop_rx_framer.sv
module mdrop_rx_framer
   import mdrop_rx_pkg::*;
#(
   parameter int OVS   = 16,
   parameter int SYNC  = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     tick,
   input  logic     rx_in,
   output logic     rx_line,
   output logic     busy,
   output logic     chr_valid,
   output logic     chr_ferr,
   output rx_char_t chr_data
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);
   localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);

   logic [SYNC-1:0] sync_q;
   fr_state_e       st;
   logic [CW-1:0]   cnt;
   logic [3:0]      bitn;
   rx_char_t        shreg;

   // synchronizer chain, depth chosen by parameter
   generate
      for (genvar i = 0; i < SYNC; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b1;
            else if (i == 0) sync_q[i] <= rx_in;
            else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign rx_line  = sync_q[SYNC-1];
   assign busy     = (st != FR_IDLE);
   assign chr_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= FR_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
         chr_valid <= 1'b0; chr_ferr <= 1'b0;
      end else begin
         chr_valid <= 1'b0;
         chr_ferr  <= 1'b0;
         if (clr) begin
            st <= FR_IDLE; cnt <= '0; bitn <= '0;
         end else begin
            case (st)
               FR_IDLE: if (!rx_line) begin st <= FR_START; cnt <= '0; end
               FR_START: if (tick) begin
                  if (cnt == HALF) begin
                     cnt <= '0; bitn <= '0;
                     st  <= rx_line ? FR_IDLE : FR_DATA;
                  end else cnt <= cnt + 1'b1;
               end
               FR_DATA: if (tick) begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     shreg <= {rx_line, shreg[CHAR_W-1:1]};
                     if (bitn == 4'(CHAR_W - 1)) st <= FR_STOP;
                     else bitn <= bitn + 1'b1;
                  end else cnt <= cnt + 1'b1;
               end
               FR_STOP: if (tick) begin
                  if (cnt == LAST) begin
                     cnt <= '0;
                     if (rx_line) begin chr_valid <= 1'b1; st <= FR_IDLE; end
                     else begin chr_ferr <= 1'b1; st <= FR_BREAK; end
                  end else cnt <= cnt + 1'b1;
               end
               FR_BREAK: if (rx_line) st <= FR_IDLE;
               default: st <= FR_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mdrop_rx_detect.sv
module mdrop_rx_detect
   import mdrop_rx_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int IDLE_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic md_enable,
   input  logic auto_rearm,
   input  logic idle_clr,
   input  logic rx_line,
   input  logic busy,
   input  logic chr_valid,
   input  logic chr_flag,
   input  logic chr_ferr,
   input  logic fifo_full,
   output logic push,
   output logic armed,
   output logic idle_flag,
   output logic overrun,
   output logic frame_err
);
   localparam int LIMIT = OVS * IDLE_BITS;
   localparam int IW    = $clog2(LIMIT + 1);

   det_state_e    st;
   logic          pend;
   logic [IW-1:0] icnt;
   logic          idle_hit;

   assign push     = chr_valid && (!md_enable || st == DET_CAPTURE || chr_flag);
   assign armed    = (st == DET_ARMED);
   assign idle_hit = pend && tick && rx_line && !busy && (icnt == IW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= DET_ARMED; pend <= 1'b0; icnt <= '0;
         idle_flag <= 1'b0; overrun <= 1'b0; frame_err <= 1'b0;
      end else if (clr) begin
         st <= DET_ARMED; pend <= 1'b0; icnt <= '0;
         idle_flag <= 1'b0; overrun <= 1'b0; frame_err <= 1'b0;
      end else begin
         if (!md_enable) st <= DET_ARMED;
         else if (chr_valid && chr_flag) st <= DET_CAPTURE;
         else if (idle_hit && auto_rearm) st <= DET_ARMED;

         if (push) pend <= 1'b1;
         else if (idle_hit) pend <= 1'b0;

         if (push || !rx_line || busy) icnt <= '0;
         else if (pend && tick) icnt <= icnt + 1'b1;

         if (idle_hit) idle_flag <= 1'b1;
         else if (idle_clr) idle_flag <= 1'b0;

         if (push && fifo_full) overrun <= 1'b1;
         if (chr_ferr) frame_err <= 1'b1;
      end
   end
endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wptr, rptr;

   assign empty = (wptr == rptr);
   assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign dout  = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full && !clr) mem[wptr[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0; rptr <= '0;
      end else if (clr) begin
         wptr <= '0; rptr <= '0;
      end else begin
         if (push && !full) wptr <= wptr + 1'b1;
         if (pop && !empty) rptr <= rptr + 1'b1;
      end
   end
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
   import mdrop_rx_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int SYNC      = 2,
   parameter int IDLE_BITS = 11,
   parameter int DEPTH     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic              rx_in,
   input  logic              md_enable,
   input  logic              auto_rearm,
   input  logic              soft_reset,
   input  logic              idle_clr,
   input  logic              rd_en,
   output logic [CHAR_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              addr_seen,
   output logic              idle_flag,
   output logic              overrun,
   output logic              frame_err
);
   initial begin
      if (OVS < 4 || (OVS % 2) != 0) $fatal(1, "OVS must be even and at least 4");
      if (SYNC < 2) $fatal(1, "SYNC must be at least 2");
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) $fatal(1, "DEPTH must be a power of two");
      if (IDLE_BITS < 1) $fatal(1, "IDLE_BITS must be positive");
   end

   logic     rx_line, busy, chr_valid, chr_ferr;
   rx_char_t chr_data;
   logic     push, armed, fifo_full, fifo_empty;

   mdrop_rx_framer #(.OVS(OVS), .SYNC(SYNC)) u_framer (
      .clk(clk), .rst_n(rst_n), .clr(soft_reset), .tick(sample_tick), .rx_in(rx_in),
      .rx_line(rx_line), .busy(busy), .chr_valid(chr_valid), .chr_ferr(chr_ferr),
      .chr_data(chr_data)
   );

   mdrop_rx_detect #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_detect (
      .clk(clk), .rst_n(rst_n), .clr(soft_reset), .tick(sample_tick),
      .md_enable(md_enable), .auto_rearm(auto_rearm), .idle_clr(idle_clr),
      .rx_line(rx_line), .busy(busy), .chr_valid(chr_valid),
      .chr_flag(chr_data[CHAR_W-1]), .chr_ferr(chr_ferr), .fifo_full(fifo_full),
      .push(push), .armed(armed), .idle_flag(idle_flag), .overrun(overrun),
      .frame_err(frame_err)
   );

   mdrop_rx_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(soft_reset), .push(push), .din(chr_data),
      .pop(rd_en), .dout(rd_data), .empty(fifo_empty), .full(fifo_full)
   );

   assign rd_valid  = !fifo_empty;
   assign addr_seen = !armed;
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_reset,
   input logic md_enable,
   input logic idle_clr,
   input logic chr_valid,
   input logic chr_flag,
   input logic push,
   input logic armed,
   input logic fifo_full,
   input logic rd_valid,
   input logic idle_flag,
   input logic overrun
);
   p_drop_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chr_valid && md_enable && armed && !chr_flag |-> !push);

   p_addr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_reset)
      chr_valid && md_enable && chr_flag |=> (!armed || !md_enable));

   p_disable_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !md_enable |=> armed);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n || soft_reset)
      push && fifo_full |=> overrun);

   p_idle_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle_flag && !idle_clr && !soft_reset |=> idle_flag);

   p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset |=> (!rd_valid && armed && !overrun));
endmodule

bind mdrop_rx mdrop_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .md_enable(md_enable),
   .idle_clr(idle_clr), .chr_valid(chr_valid), .chr_flag(chr_data[8]), .push(push),
   .armed(armed), .fifo_full(fifo_full), .rd_valid(rd_valid), .idle_flag(idle_flag),
   .overrun(overrun)
);

// File: tb/mdrop_rx_tb_top.sv
`timescale 1ns/1ps
module mdrop_rx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic       md_enable = 1'b0, auto_rearm = 1'b0, soft_reset = 1'b0, idle_clr = 1'b0, rd_en = 1'b0;
   logic [8:0] rd_data;
   logic       rd_valid, addr_seen, idle_flag, overrun, frame_err;
   int         n_chk = 0, n_fail = 0;
   bit         model_capt = 1'b0;

   always #4 clk = ~clk;

   mdrop_rx dut_i (
      .clk(clk), .rst_n(rst_n), .sample_tick(1'b1), .rx_in(rx_in),
      .md_enable(md_enable), .auto_rearm(auto_rearm), .soft_reset(soft_reset),
      .idle_clr(idle_clr), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .addr_seen(addr_seen), .idle_flag(idle_flag), .overrun(overrun), .frame_err(frame_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bit_time(input logic v);
      rx_in = v;
      repeat (16) @(negedge clk);
   endtask

   task automatic send_char(input logic [8:0] c, input logic stop_ok = 1'b1);
      bit_time(1'b0);
      for (int i = 0; i < 9; i++) bit_time(c[i]);
      bit_time(stop_ok);
      rx_in = 1'b1;
   endtask

   task automatic pop_expect(input string req, input logic [8:0] exp);
      chk(req, int'(rd_valid), 1);
      chk(req, int'(rd_data), int'(exp));
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic pulse_soft_reset();
      soft_reset = 1'b1; @(negedge clk); soft_reset = 1'b0; @(negedge clk);
      model_capt = 1'b0;
   endtask

   function automatic bit model_store(input bit md, input logic [8:0] c);
      return !md || model_capt || c[8];
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset rd_valid", int'(rd_valid), 0);
      chk("R11 reset flags", int'({idle_flag, overrun, frame_err, addr_seen}), 0);

      // R5 / R1: disabled mode stores everything, field layout
      send_char(9'h1A5); pop_expect("R5 R1 flag stored", 9'h1A5);
      send_char(9'h03C); pop_expect("R5 R1 data stored", 9'h03C);

      // R2: armed drop
      md_enable = 1'b1; @(negedge clk);
      send_char(9'h055);
      chk("R2 data dropped while armed", int'(rd_valid), 0);
      chk("R2 still armed", int'(addr_seen), 0);

      // R3: address captured, then data stored
      send_char(9'h112);
      chk("R3 capturing", int'(addr_seen), 1);
      send_char(9'h0EE);
      pop_expect("R3 address", 9'h112);
      pop_expect("R3 data after address", 9'h0EE);

      // R4: enable toggle re-arms
      md_enable = 1'b0; @(negedge clk); @(negedge clk); md_enable = 1'b1; @(negedge clk);
      chk("R4 rearmed after toggle", int'(addr_seen), 0);
      send_char(9'h077);
      chk("R4 data dropped after toggle", int'(rd_valid), 0);

      // R6 / R7 idle without auto-rearm
      send_char(9'h101); pop_expect("R3 addr before idle", 9'h101);
      repeat (120) @(negedge clk);
      chk("R6 no idle before window", int'(idle_flag), 0);
      repeat (100) @(negedge clk);
      chk("R6 idle after window", int'(idle_flag), 1);
      chk("R7 no rearm without auto", int'(addr_seen), 1);
      repeat (50) @(negedge clk);
      chk("R6 idle sticky", int'(idle_flag), 1);
      idle_clr = 1'b1; @(negedge clk); idle_clr = 1'b0; @(negedge clk);
      chk("R6 idle cleared", int'(idle_flag), 0);
      send_char(9'h022); pop_expect("R7 capture kept after idle", 9'h022);

      // R7 auto-rearm
      auto_rearm = 1'b1;
      repeat (250) @(negedge clk);
      chk("R7 idle with auto", int'(idle_flag), 1);
      chk("R7 auto rearmed", int'(addr_seen), 0);
      send_char(9'h033);
      chk("R7 data dropped after auto rearm", int'(rd_valid), 0);
      auto_rearm = 1'b0;

      // R11 soft reset mid-message
      send_char(9'h1F0); send_char(9'h044);
      pulse_soft_reset();
      chk("R11 fifo emptied", int'(rd_valid), 0);
      chk("R11 rearmed, idle cleared", int'({addr_seen, idle_flag}), 0);
      send_char(9'h099);
      chk("R11 data dropped after soft reset", int'(rd_valid), 0);

      // R9 short glitch
      md_enable = 1'b0; @(negedge clk);
      rx_in = 1'b0; repeat (4) @(negedge clk); rx_in = 1'b1;
      repeat (200) @(negedge clk);
      chk("R9 glitch ignored", int'({rd_valid, frame_err}), 0);

      // R10 framing error
      send_char(9'h0AB, 1'b0);
      repeat (16) @(negedge clk);
      chk("R10 frame_err set", int'(frame_err), 1);
      chk("R10 char discarded", int'(rd_valid), 0);
      send_char(9'h0CD); pop_expect("R10 recovers after error", 9'h0CD);

      // R8 overrun
      for (int i = 0; i < 9; i++) send_char(9'(i * 7 + 3));
      chk("R8 overrun set", int'(overrun), 1);
      for (int i = 0; i < 8; i++) pop_expect("R8 fifo order", 9'(i * 7 + 3));
      chk("R8 ninth dropped", int'(rd_valid), 0);
      pulse_soft_reset();
      chk("R11 flags cleared", int'({overrun, frame_err}), 0);

      // Random stream against model
      for (int n = 0; n < 60; n++) begin
         logic [8:0] c;
         bit st;
         if ($urandom_range(0, 9) == 0) begin
            md_enable = ~md_enable; @(negedge clk);
            if (!md_enable) model_capt = 1'b0;
         end
         c = {($urandom_range(0, 3) == 0), 8'($urandom)};
         st = model_store(md_enable, c);
         if (md_enable && c[8]) model_capt = 1'b1;
         send_char(c);
         if (st) pop_expect("R2 R3 R5 random stored", c);
         else chk("R2 random dropped", int'(rd_valid), 0);
         chk("R3 R4 random state", int'(addr_seen), int'(model_capt));
         repeat ($urandom_range(0, 32)) @(negedge clk);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule